// File: doc/BRIEF.md
# Strided and Indexed Vector Memory Unit

This unit converts a single vector load or store command into a sequence of per-lane memory requests. A command carries a base address, a stride, a vector length and an access mode. In strided mode each element's address is derived from the base plus a stride multiple. In indexed mode each lane adds its own offset to the base. Elements are handled in groups of `LANES`: every group forms one address per lane in parallel, then the active lanes are serialized into a request queue that feeds a single shared data-cache port.

Store data from the lane selected for issue passes through a write crossbar into a write queue that drains in step with the request queue. Responses come back tagged with their lane number. A registered read crossbar steers each load word to its lane's read port. During a command, the lanes supply per-group index and store data for the group shown on `grp_o`. Each request is held until the memory accepts it, and a stall output reports back-pressure. A single-cycle done pulse marks the point when every element has been acknowledged.

Top module: `vmu_top`

## Requirements
- R1: In strided mode (`cmd_indexed_i`=0) the request for element e carries address `base + stride*e` (modulo 2^AW). For lane i of group g, e = g*LANES + i, so each group's base moves on by `stride*LANES`.
- R2: In indexed mode (`cmd_indexed_i`=1) the request for lane i of group g carries address `base + lane_idx_i[i*AW +: AW]`, sampled while `grp_o` equals g.
- R3: Requests leave in element order: groups ascending, and lanes ascending within a group. `mem_req_lane_o` carries the lane number i of the element.
- R4: Elements with index at or above `cmd_vlen_i` produce no request. With a length of zero the command issues nothing and still completes with a done pulse.
- R5: For a store (`cmd_store_i`=1) every request has `mem_req_we_o`=1 and `mem_req_wdata_o` equal to `lane_wdata_i[i*DW +: DW]` for that element's lane and group. For a load `mem_req_we_o`=0.
- R6: A response with `mem_rsp_valid_i`=1 to a load raises `rd_valid_o[t]` one cycle later, where t is `mem_rsp_lane_i`. In that same cycle `rd_data_o[t*DW +: DW]` holds `mem_rsp_data_i`. At most one lane is flagged per cycle, and responses to stores flag no lane.
- R7: `stall_o` is high whenever the request queue or the write queue is full. While `mem_req_ready_i` is low a pending request stays unchanged, and no element is lost or duplicated.
- R8: `done_o` pulses for exactly one cycle once the number of responses equals the vector length. `cmd_ready_o` is high only when the unit is idle, and no request is presented while idle.
- R9: After reset `cmd_ready_o`=1, and `done_o`, `stall_o`, `mem_req_valid_o` and `rd_valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Unit idle, command accepted when valid |
| cmd_store_i | input | 1 | 1 = store, 0 = load |
| cmd_indexed_i | input | 1 | 1 = indexed, 0 = strided |
| cmd_base_i | input | AW | Base address |
| cmd_stride_i | input | AW | Stride between elements |
| cmd_vlen_i | input | VLW | Number of elements |
| grp_o | output | VLW | Group whose lane inputs are consumed |
| lane_idx_i | input | LANES*AW | Per-lane index offsets for group `grp_o` |
| lane_wdata_i | input | LANES*DW | Per-lane store data for group `grp_o` |
| mem_req_valid_o | output | 1 | Request queue head valid |
| mem_req_ready_i | input | 1 | Memory accepts head |
| mem_req_we_o | output | 1 | Head is a write |
| mem_req_addr_o | output | AW | Head address |
| mem_req_lane_o | output | LW | Head lane tag |
| mem_req_wdata_o | output | DW | Write queue head data |
| mem_rsp_valid_i | input | 1 | Memory response |
| mem_rsp_lane_i | input | LW | Response lane tag |
| mem_rsp_data_i | input | DW | Response read data |
| rd_valid_o | output | LANES | Per-lane load return strobe |
| rd_data_o | output | LANES*DW | Per-lane load return data |
| stall_o | output | 1 | A queue is full |
| done_o | output | 1 | Command complete pulse |

## Verification
The assertions check several properties on every cycle. A request the memory has not taken must stay fixed. A full queue under back-pressure must keep stall asserted. Done must stay a single-cycle pulse. Read strobes must be one-hot at most, and each must follow a response. No request may appear while the unit is idle. Other behaviours can only be shown by the bench's scenarios, because they depend on the whole command: the address arithmetic for strided and indexed modes across group boundaries, the element order, the suppression of elements past the vector length (including a zero length), the store data routing, and the loss-free recovery after a long stall.

// File: rtl/vmu_pkg.sv
package vmu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } vmu_state_e;
endpackage

// File: rtl/vmu_fifo.sv
module vmu_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end
endmodule

// File: rtl/vmu_lane_agen.sv
module vmu_lane_agen #(
  parameter int AW   = 32,
  parameter int LANE = 0
) (
  input  logic          indexed_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] grp_base_i,
  input  logic [AW-1:0] stride_i,
  input  logic [AW-1:0] idx_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] str_off;
  assign str_off = stride_i * AW'(LANE);
  assign addr_o  = indexed_i ? (base_i + idx_i) : (grp_base_i + str_off);
endmodule

// File: rtl/vmu_rd_xbar.sv
module vmu_rd_xbar #(
  parameter int LANES = 4,
  parameter int DW    = 32,
  parameter int LW    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [LW-1:0]     lane_i,
  input  logic [DW-1:0]     data_i,
  output logic [LANES-1:0]  rd_valid_o,
  output logic [LANES*DW-1:0] rd_data_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic hit;
    assign hit = en_i && (lane_i == LW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_valid_o[i]          <= 1'b0;
        rd_data_o[i*DW +: DW]  <= '0;
      end else begin
        rd_valid_o[i] <= hit;
        if (hit) rd_data_o[i*DW +: DW] <= data_i;
      end
    end
  end
endmodule

// File: rtl/vmu_top.sv
module vmu_top
  import vmu_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int VLW    = 8,
  parameter int QDEPTH = 4,
  localparam int LW    = $clog2(LANES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  output logic                cmd_ready_o,
  input  logic                cmd_store_i,
  input  logic                cmd_indexed_i,
  input  logic [AW-1:0]       cmd_base_i,
  input  logic [AW-1:0]       cmd_stride_i,
  input  logic [VLW-1:0]      cmd_vlen_i,
  output logic [VLW-1:0]      grp_o,
  input  logic [LANES*AW-1:0] lane_idx_i,
  input  logic [LANES*DW-1:0] lane_wdata_i,
  output logic                mem_req_valid_o,
  input  logic                mem_req_ready_i,
  output logic                mem_req_we_o,
  output logic [AW-1:0]       mem_req_addr_o,
  output logic [LW-1:0]       mem_req_lane_o,
  output logic [DW-1:0]       mem_req_wdata_o,
  input  logic                mem_rsp_valid_i,
  input  logic [LW-1:0]       mem_rsp_lane_i,
  input  logic [DW-1:0]       mem_rsp_data_i,
  output logic [LANES-1:0]    rd_valid_o,
  output logic [LANES*DW-1:0] rd_data_o,
  output logic                stall_o,
  output logic                done_o
);
  localparam int EW  = VLW + LW + 1;
  localparam int RQW = 1 + LW + AW;

  vmu_state_e     state_q;
  logic           store_q, indexed_q, done_q;
  logic [AW-1:0]  base_q, stride_q, grp_base_q;
  logic [VLW-1:0] vlen_q, grp_q;
  logic [EW-1:0]  elem_base_q, ack_q;
  logic [LANES-1:0] pend_q;

  logic [AW-1:0]  lane_addr [LANES];
  logic [LW-1:0]  sel;
  logic           push, pop, rq_full, rq_empty, wq_full, wq_empty;
  logic [RQW-1:0] rq_din, rq_dout;
  logic [DW-1:0]  wq_din;
  logic [EW-1:0]  next_eb;
  logic           last_grp;

  function automatic logic [LANES-1:0] act_mask(logic [EW-1:0] eb, logic [VLW-1:0] vl);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = (eb + EW'(i)) < EW'(vl);
    return m;
  endfunction

  // per-lane address generation
  for (genvar i = 0; i < LANES; i++) begin : g_agen
    vmu_lane_agen #(.AW(AW), .LANE(i)) u_agen (
      .indexed_i (indexed_q),
      .base_i    (base_q),
      .grp_base_i(grp_base_q),
      .stride_i  (stride_q),
      .idx_i     (lane_idx_i[i*AW +: AW]),
      .addr_o    (lane_addr[i])
    );
  end

  // lowest pending lane issues first
  always_comb begin
    sel = '0;
    for (int i = LANES - 1; i >= 0; i--) if (pend_q[i]) sel = LW'(i);
  end

  assign next_eb  = elem_base_q + EW'(LANES);
  assign last_grp = next_eb >= EW'(vlen_q);
  assign stall_o  = rq_full || wq_full;
  assign push     = (state_q == ST_ISSUE) && (|pend_q) && !stall_o;
  assign pop      = mem_req_valid_o && mem_req_ready_i;

  assign rq_din = {store_q, sel, lane_addr[sel]};
  assign wq_din = lane_wdata_i[sel*DW +: DW]; // write crossbar

  vmu_fifo #(.W(RQW), .DEPTH(QDEPTH)) u_req_q (
    .clk_i, .rst_ni,
    .push_i (push),
    .din_i  (rq_din),
    .pop_i  (pop),
    .dout_o (rq_dout),
    .full_o (rq_full),
    .empty_o(rq_empty)
  );

  vmu_fifo #(.W(DW), .DEPTH(QDEPTH)) u_wr_q (
    .clk_i, .rst_ni,
    .push_i (push && store_q),
    .din_i  (wq_din),
    .pop_i  (pop && mem_req_we_o),
    .dout_o (mem_req_wdata_o),
    .full_o (wq_full),
    .empty_o(wq_empty)
  );

  assign mem_req_valid_o = !rq_empty && (!rq_dout[RQW-1] || !wq_empty);
  assign mem_req_we_o    = rq_dout[RQW-1];
  assign mem_req_lane_o  = rq_dout[AW +: LW];
  assign mem_req_addr_o  = rq_dout[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      store_q     <= 1'b0;
      indexed_q   <= 1'b0;
      base_q      <= '0;
      stride_q    <= '0;
      grp_base_q  <= '0;
      vlen_q      <= '0;
      grp_q       <= '0;
      elem_base_q <= '0;
      ack_q       <= '0;
      pend_q      <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q != ST_IDLE && mem_rsp_valid_i) ack_q <= ack_q + 1'b1;
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          store_q     <= cmd_store_i;
          indexed_q   <= cmd_indexed_i;
          base_q      <= cmd_base_i;
          stride_q    <= cmd_stride_i;
          grp_base_q  <= cmd_base_i;
          vlen_q      <= cmd_vlen_i;
          grp_q       <= '0;
          elem_base_q <= '0;
          ack_q       <= '0;
          pend_q      <= act_mask('0, cmd_vlen_i);
          state_q     <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (push) begin
            pend_q[sel] <= 1'b0;
          end else if (pend_q == '0) begin
            if (last_grp) begin
              state_q <= ST_DRAIN;
            end else begin
              grp_q       <= grp_q + 1'b1;
              elem_base_q <= next_eb;
              grp_base_q  <= grp_base_q + stride_q * AW'(LANES);
              pend_q      <= act_mask(next_eb, vlen_q);
            end
          end
        end
        ST_DRAIN: if (ack_q == EW'(vlen_q)) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign grp_o       = grp_q;
  assign done_o      = done_q;

  vmu_rd_xbar #(.LANES(LANES), .DW(DW), .LW(LW)) u_rd_xbar (
    .clk_i, .rst_ni,
    .en_i      (mem_rsp_valid_i && !store_q),
    .lane_i    (mem_rsp_lane_i),
    .data_i    (mem_rsp_data_i),
    .rd_valid_o(rd_valid_o),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/vmu_chk.sv
module vmu_chk #(
  parameter int LANES = 4,
  parameter int AW    = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_ready_o,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic             mem_req_we_o,
  input logic [AW-1:0]    mem_req_addr_o,
  input logic             mem_rsp_valid_i,
  input logic [LANES-1:0] rd_valid_o,
  input logic             stall_o,
  input logic             done_o
);
  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o));

  // R7
  stall_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o && !mem_req_ready_i |=> stall_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !mem_req_valid_o);

  // R6
  rd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_valid_o));

  // R6
  rd_after_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rd_valid_o) |-> $past(mem_rsp_valid_i));
endmodule

bind vmu_top vmu_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_ready_o    (cmd_ready_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_we_o   (mem_req_we_o),
  .mem_req_addr_o (mem_req_addr_o),
  .mem_rsp_valid_i(mem_rsp_valid_i),
  .rd_valid_o     (rd_valid_o),
  .stall_o        (stall_o),
  .done_o         (done_o)
);

// File: tb/sim_vmu_top.sv
`timescale 1ns/1ps
module sim_vmu_top;
  localparam int LANES = 4, AW = 32, DW = 32, VLW = 8, QDEPTH = 4;
  localparam int LW = $clog2(LANES);
  localparam int LAT = 3;

  logic clk = 0, rst_ni = 0;
  always #2.5 clk = ~clk;

  logic cmd_valid = 0, cmd_ready, cmd_store = 0, cmd_indexed = 0;
  logic [AW-1:0] cmd_base = '0, cmd_stride = '0;
  logic [VLW-1:0] cmd_vlen = '0, grp;
  logic [LANES*AW-1:0] lane_idx;
  logic [LANES*DW-1:0] lane_wdata;
  logic req_valid, req_ready = 1, req_we;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_lane;
  logic [DW-1:0] req_wdata;
  logic rsp_valid = 0;
  logic [LW-1:0] rsp_lane = '0;
  logic [DW-1:0] rsp_data = '0;
  logic [LANES-1:0] rd_valid;
  logic [LANES*DW-1:0] rd_data;
  logic stall, done;

  vmu_top #(.LANES(LANES), .AW(AW), .DW(DW), .VLW(VLW), .QDEPTH(QDEPTH)) u0 (
    .clk_i(clk), .rst_ni,
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_store_i(cmd_store), .cmd_indexed_i(cmd_indexed),
    .cmd_base_i(cmd_base), .cmd_stride_i(cmd_stride), .cmd_vlen_i(cmd_vlen),
    .grp_o(grp), .lane_idx_i(lane_idx), .lane_wdata_i(lane_wdata),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready),
    .mem_req_we_o(req_we), .mem_req_addr_o(req_addr),
    .mem_req_lane_o(req_lane), .mem_req_wdata_o(req_wdata),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_lane_i(rsp_lane), .mem_rsp_data_i(rsp_data),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .stall_o(stall), .done_o(done)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] seed_k = 0;
  logic idx_mode = 0;

  task automatic chk(input bit ok, input string req, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic logic [AW-1:0] idx_f(logic [31:0] s, int g, int i);
    return ((s * 32'd2654435761) ^ (32'(g) * 32'd97) ^ (32'(i) << 8)) & 32'h0000_FFFC;
  endfunction
  function automatic logic [DW-1:0] wd_f(logic [31:0] s, int g, int i);
    return {s[15:0], 8'(g), 8'(i)};
  endfunction
  function automatic logic [DW-1:0] rd_f(logic [AW-1:0] a);
    return a ^ 32'h5A3C_0000;
  endfunction

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_idx[i*AW +: AW]   = idx_f(seed_k, int'(grp), i);
      lane_wdata[i*DW +: DW] = wd_f(seed_k, int'(grp), i);
    end
  end

  // expected request stream
  logic [AW-1:0] eq_addr[$];
  logic [LW-1:0] eq_lane[$];
  logic          eq_we[$];
  logic [DW-1:0] eq_wd[$];

  // memory pipe
  logic          p_v[LAT], p_we[LAT];
  logic [LW-1:0] p_l[LAT];
  logic [DW-1:0] p_d[LAT];
  logic          pr_v = 0, pr_load = 0;
  logic [LW-1:0] pr_l = '0;
  logic [DW-1:0] pr_d = '0;
  int hold_n = 0, done_cnt = 0;
  bit stall_seen = 0, mon_on = 0;

  initial for (int k = 0; k < LAT; k++) begin p_v[k] = 0; p_we[k] = 0; p_l[k] = '0; p_d[k] = '0; end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (mon_on) begin
      if (done) done_cnt++;
      // R6 read crossbar output from last presented response
      if (pr_v && pr_load)
        chk(rd_valid == (LANES'(1) << pr_l) && rd_data[pr_l*DW +: DW] == pr_d, "R6",
            $sformatf("rd_valid=%b data=%h expected lane %0d data=%h", rd_valid,
                      rd_data[pr_l*DW +: DW], pr_l, pr_d));
      else if (rd_valid != '0)
        chk(0, "R6", $sformatf("rd_valid=%b expected=0", rd_valid));
      // back-pressure
      if (hold_n > 0) begin
        if (hold_n == 1) stall_seen = stall;
        hold_n--;
        req_ready = 0;
      end else req_ready = 1;
      // request side
      begin
        logic fv, fwe; logic [LW-1:0] fl; logic [DW-1:0] fd;
        fv = req_valid && req_ready; fwe = 0; fl = '0; fd = '0;
        if (fv) begin
          if (eq_addr.size() == 0)
            chk(0, "R4", $sformatf("extra request addr=%h expected none", req_addr));
          else begin
            logic [AW-1:0] ea; logic [LW-1:0] el; logic ew; logic [DW-1:0] ed;
            ea = eq_addr.pop_front(); el = eq_lane.pop_front();
            ew = eq_we.pop_front(); ed = eq_wd.pop_front();
            chk(req_addr == ea, idx_mode ? "R2" : "R1",
                $sformatf("addr=%h expected=%h", req_addr, ea));
            chk(req_lane == el, "R3", $sformatf("lane=%0d expected=%0d", req_lane, el));
            chk(req_we == ew && (!ew || req_wdata == ed), "R5",
                $sformatf("we=%b wdata=%h expected we=%b wdata=%h", req_we, req_wdata, ew, ed));
          end
          fwe = req_we; fl = req_lane; fd = rd_f(req_addr);
        end
        pr_v = p_v[0]; pr_load = !p_we[0]; pr_l = p_l[0]; pr_d = p_d[0];
        for (int k = 0; k < LAT - 1; k++) begin
          p_v[k] = p_v[k+1]; p_we[k] = p_we[k+1]; p_l[k] = p_l[k+1]; p_d[k] = p_d[k+1];
        end
        p_v[LAT-1] = fv; p_we[LAT-1] = fwe; p_l[LAT-1] = fl; p_d[LAT-1] = fd;
        rsp_valid = pr_v; rsp_lane = pr_l; rsp_data = pr_d;
      end
    end
  end

  task automatic run_cmd(input bit st, input bit ix, input logic [AW-1:0] b,
                         input logic [AW-1:0] s, input int vl, input logic [31:0] sd,
                         input int hold);
    int w;
    @(negedge clk);
    seed_k = sd; idx_mode = ix;
    for (int e = 0; e < vl; e++) begin
      int g, i;
      g = e / LANES; i = e % LANES;
      eq_addr.push_back(ix ? b + idx_f(sd, g, i) : b + s * 32'(e));
      eq_lane.push_back(LW'(i));
      eq_we.push_back(st);
      eq_wd.push_back(wd_f(sd, g, i));
    end
    done_cnt = 0;
    hold_n = hold;
    cmd_store = st; cmd_indexed = ix; cmd_base = b; cmd_stride = s;
    cmd_vlen = VLW'(vl); cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    w = 0;
    while (done_cnt == 0 && w < 3000) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R8", $sformatf("done pulses=%0d expected=1", done_cnt));
    chk(eq_addr.size() == 0, "R4", $sformatf("missing requests=%0d expected=0", eq_addr.size()));
    chk(cmd_ready == 1, "R8", $sformatf("cmd_ready=%b expected=1", cmd_ready));
    eq_addr.delete(); eq_lane.delete(); eq_we.delete(); eq_wd.delete();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R9
    chk(cmd_ready == 1 && done == 0 && stall == 0 && req_valid == 0 && rd_valid == '0, "R9",
        $sformatf("ready=%b done=%b stall=%b rv=%b rd=%b expected 1,0,0,0,0",
                  cmd_ready, done, stall, req_valid, rd_valid));
    mon_on = 1;
    // directed corners
    run_cmd(0, 0, 32'h1000, 32'd4, 4, 32'd1, 0);        // R1 one group
    run_cmd(0, 0, 32'h2000, 32'd12, 11, 32'd2, 0);      // R1 groups, R4 partial last
    run_cmd(1, 0, 32'h3000, 32'hFFFF_FFF8, 6, 32'd3, 0); // R5 negative stride
    run_cmd(0, 1, 32'h4000, 32'd0, 9, 32'd4, 0);        // R2
    run_cmd(1, 1, 32'h5000, 32'd0, 7, 32'd5, 0);        // R2 R5
    run_cmd(0, 0, 32'h6000, 32'd4, 0, 32'd6, 0);        // R4 zero length
    run_cmd(0, 0, 32'h7000, 32'd4, 1, 32'd7, 0);        // R4 single
    run_cmd(1, 0, 32'h8000, 32'd8, 12, 32'd8, 20);      // R7 stall on store
    chk(stall_seen == 1, "R7", $sformatf("stall=%b expected=1", stall_seen));
    run_cmd(0, 1, 32'h9000, 32'd0, 13, 32'd9, 20);      // R7 stall on load
    chk(stall_seen == 1, "R7", $sformatf("stall=%b expected=1", stall_seen));
    for (int n = 0; n < 30; n++) begin
      logic [31:0] r;
      r = $urandom;
      run_cmd(r[0], r[1], $urandom & 32'hFFFF_FFFC, 32'($urandom % 64) - 32'd16,
              int'($urandom % 21), $urandom, r[2] ? int'($urandom % 12) : 0);
    end
    run_cmd(0, 0, 32'hFFFF_FFF0, 32'd8, 5, 32'd10, 0);  // R1 wrap
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule